// File: doc/BRIEF.md
# I2C Slave Own-Address Recognition Unit

This unit sits behind the bit-level receiver of an I2C slave and decides, during the address phase of each transfer, whether this controller is the one being addressed. The receiver gives it a one-cycle pulse for each start or repeated start and a one-cycle strobe for each assembled byte. The unit compares the first byte, or the first two bytes, of the transfer with its configured addresses. It raises a match flag, a transfer direction bit and a flag saying whether the secondary address is the one that hit. The receiver's ACK logic then acts on these outputs.

The primary address is ten bits wide and can be used in 7-bit or 10-bit mode. An eight-bit secondary register holds a second 7-bit address in bits 7:1, and its bit 0 turns dual-address recognition on. In 10-bit mode the unit expects a header byte and then a low-address byte, and it declares a match only when both agree. Once the unit has decided, match or miss, it holds that decision until the next start.

Top module: `i2c_own_addr_match`

## Requirements
- R1: After reset, match_o, sec_hit_o and dir_o are all 0.
- R2: In 7-bit mode (ten_bit_i=0), the first byte after a start matches when byte_i[7:1] equals prim_addr_i[7:1]. prim_addr_i[9:8] and prim_addr_i[0] have no effect. match_o goes high in the cycle after the byte strobe.
- R3: With the dual enable (sec_cfg_i[0]) at 0, a first byte whose bits 7:1 equal sec_cfg_i[7:1] does not match, unless it also equals the primary address.
- R4: With the dual enable at 1, a first byte whose bits 7:1 equal sec_cfg_i[7:1] matches and sets sec_hit_o=1. When a byte equals both addresses, the primary one wins and sec_hit_o stays 0. sec_hit_o is never 1 while match_o is 0.
- R5: dir_o takes bit 0 of the first byte after a start. It is updated in the same cycle as the decision on that byte, whether or not the byte matches.
- R6: In 10-bit mode the first byte must be {11110, prim_addr_i[9:8], rw}, and the following byte must equal prim_addr_i[7:0]. match_o stays 0 after the header alone and goes high in the cycle after the second byte.
- R7: In 10-bit mode, a mismatch in either byte leaves match_o at 0 until the next start, whatever bytes follow.
- R8: The secondary address is never used in 10-bit mode.
- R9: A start pulse clears match_o, sec_hit_o and dir_o in the next cycle and restarts recognition. When a start and a byte strobe arrive in the same cycle, the start wins and the byte is dropped.
- R10: Once matched, later bytes leave match_o, dir_o and sec_hit_o unchanged until the next start.
- R11: Bytes strobed after reset but before any start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing of the primary address |
| prim_addr_i | input | 10 | Primary own address |
| sec_cfg_i | input | 8 | Secondary 7-bit address in bits 7:1, dual enable in bit 0 |
| start_i | input | 1 | One-cycle pulse for a start or repeated start |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte, first bit received in bit 7 |
| match_o | output | 1 | This slave is addressed |
| dir_o | output | 1 | R/W bit of the first address byte (1 = read) |
| sec_hit_o | output | 1 | The match came from the secondary address |

## Verification
The bench configures the primary address with nonzero don't-care bits, so a design that compares all ten bits in 7-bit mode would miss a valid address. It sends a byte that equals both addresses; a design that gives the secondary address priority would raise sec_hit_o. In 10-bit mode it checks that a correct header alone gives no match, and it corrupts the header and the low byte in turn. A design that declares a match too early, or that resumes matching on later bytes after a miss, fails these checks. It also sends a start together with a byte, and sends bytes before any start has been seen; a design that lets either byte through would show a stray match or direction bit.

// File: rtl/i2c_oar_pkg.sv
package i2c_oar_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int PFX_W  = BYTE_W - 1 - HI_W;
  localparam logic [PFX_W-1:0] HDR_PFX = {PFX_W{1'b1}} << 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // before any start, or after a miss
    ST_FIRST = 2'd1,  // waiting for the first address byte
    ST_LOW   = 2'd2,  // 10-bit header accepted, waiting for low byte
    ST_HIT   = 2'd3   // addressed
  } oar_state_t;

  function automatic logic f_hit7(input logic [BYTE_W-1:0] b,
                                  input logic [BYTE_W-2:0] a7);
    return b[BYTE_W-1:1] == a7;
  endfunction

  function automatic logic f_hdr(input logic [BYTE_W-1:0] b,
                                 input logic [HI_W-1:0] hi);
    return b[BYTE_W-1:1] == {HDR_PFX, hi};
  endfunction
endpackage

// File: rtl/i2c_oar_cmp.sv
module i2c_oar_cmp
  import i2c_oar_pkg::*;
(
  input  logic              ten_bit_i,
  input  logic [ADDR_W-1:0] prim_addr_i,
  input  logic [BYTE_W-1:0] sec_cfg_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              p7_hit_o,
  output logic              s7_hit_o,
  output logic              hdr_hit_o,
  output logic              low_hit_o
);
  logic dual_en;
  assign dual_en   = sec_cfg_i[0] && !ten_bit_i;
  assign p7_hit_o  = f_hit7(byte_i, prim_addr_i[BYTE_W-1:1]);
  assign s7_hit_o  = dual_en && f_hit7(byte_i, sec_cfg_i[BYTE_W-1:1]);
  assign hdr_hit_o = f_hdr(byte_i, prim_addr_i[ADDR_W-1:BYTE_W]);
  assign low_hit_o = byte_i == prim_addr_i[BYTE_W-1:0];
endmodule

// File: rtl/i2c_oar_fsm.sv
module i2c_oar_fsm
  import i2c_oar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ten_bit_i,
  input  logic start_i,
  input  logic byte_vld_i,
  input  logic rw_bit_i,
  input  logic p7_hit_i,
  input  logic s7_hit_i,
  input  logic hdr_hit_i,
  input  logic low_hit_i,
  output logic match_o,
  output logic dir_o,
  output logic sec_hit_o,
  output logic hdr_pending_o
);
  oar_state_t state_q, state_d;
  logic dir_d, sec_d;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_o;
    sec_d   = sec_hit_o;
    if (start_i) begin
      state_d = ST_FIRST;
      dir_d   = 1'b0;
      sec_d   = 1'b0;
    end else if (byte_vld_i) begin
      case (state_q)
        ST_FIRST: begin
          dir_d = rw_bit_i;
          if (ten_bit_i)
            state_d = hdr_hit_i ? ST_LOW : ST_IDLE;
          else if (p7_hit_i)
            state_d = ST_HIT;
          else if (s7_hit_i) begin
            state_d = ST_HIT;
            sec_d   = 1'b1;
          end else
            state_d = ST_IDLE;
        end
        ST_LOW:  state_d = low_hit_i ? ST_HIT : ST_IDLE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dir_o     <= 1'b0;
      sec_hit_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      dir_o     <= dir_d;
      sec_hit_o <= sec_d;
    end
  end

  assign match_o       = state_q == ST_HIT;
  assign hdr_pending_o = state_q == ST_LOW;
endmodule

// File: rtl/i2c_own_addr_match.sv
module i2c_own_addr_match
  import i2c_oar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_bit_i,
  input  logic [ADDR_W-1:0] prim_addr_i,
  input  logic [BYTE_W-1:0] sec_cfg_i,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              match_o,
  output logic              dir_o,
  output logic              sec_hit_o
);
  logic p7_hit, s7_hit, hdr_hit, low_hit, hdr_pending;

  i2c_oar_cmp u_cmp (
    .ten_bit_i  (ten_bit_i),
    .prim_addr_i(prim_addr_i),
    .sec_cfg_i  (sec_cfg_i),
    .byte_i     (byte_i),
    .p7_hit_o   (p7_hit),
    .s7_hit_o   (s7_hit),
    .hdr_hit_o  (hdr_hit),
    .low_hit_o  (low_hit)
  );

  i2c_oar_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ten_bit_i    (ten_bit_i),
    .start_i      (start_i),
    .byte_vld_i   (byte_vld_i),
    .rw_bit_i     (byte_i[0]),
    .p7_hit_i     (p7_hit),
    .s7_hit_i     (s7_hit),
    .hdr_hit_i    (hdr_hit),
    .low_hit_i    (low_hit),
    .match_o      (match_o),
    .dir_o        (dir_o),
    .sec_hit_o    (sec_hit_o),
    .hdr_pending_o(hdr_pending)
  );
endmodule

// File: rtl/i2c_own_addr_match_chk.sv
module i2c_own_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic ten_bit_i,
  input logic start_i,
  input logic byte_vld_i,
  input logic match_o,
  input logic dir_o,
  input logic sec_hit_o,
  input logic hdr_pending
);
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !match_o && !sec_hit_o && !dir_o);

  assert_hold_after_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    match_o && !start_i |=> match_o && $stable(dir_o) && $stable(sec_hit_o));

  assert_sec_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hit_o |-> match_o);

  assert_hit_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) |-> $past(byte_vld_i) && !$past(start_i));

  assert_ten_needs_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) && $past(ten_bit_i) |-> $past(hdr_pending));

  assert_header_no_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pending |-> !match_o);

  assert_no_dual_in_ten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) && $past(ten_bit_i) |-> !sec_hit_o);
endmodule

bind i2c_own_addr_match i2c_own_addr_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ten_bit_i  (ten_bit_i),
  .start_i    (start_i),
  .byte_vld_i (byte_vld_i),
  .match_o    (match_o),
  .dir_o      (dir_o),
  .sec_hit_o  (sec_hit_o),
  .hdr_pending(hdr_pending)
);

// File: tb/i2c_own_addr_match_tb.sv
module i2c_own_addr_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_bit_i = 1'b0;
  logic [9:0] prim_addr_i = '0;
  logic [7:0] sec_cfg_i = '0;
  logic       start_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       match_o, dir_o, sec_hit_o;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  i2c_own_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .ten_bit_i(ten_bit_i), .prim_addr_i(prim_addr_i),
    .sec_cfg_i(sec_cfg_i), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .match_o(match_o), .dir_o(dir_o), .sec_hit_o(sec_hit_o)
  );

  // expected triple is {match, sec_hit, dir}
  task automatic check(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {match_o, sec_hit_o, dir_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {match,sec,dir} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  function automatic logic [7:0] hdr10(input logic [9:0] a, input logic rw);
    return {5'b11110, a[9:8], rw};
  endfunction

  task automatic t_reset();
    check("R1 reset", 3'b000);
    prim_addr_i = 10'h3A5; sec_cfg_i = 8'h00; ten_bit_i = 1'b0;
    send(8'hA4);
    check("R11 byte before start", 3'b000);
  endtask

  task automatic t_prim7();
    do_start(); send(8'hA5);
    check("R2 R5 primary read", 3'b101);
    send(8'h00);
    check("R10 later byte ignored", 3'b101);
    do_start();
    check("R9 start clears", 3'b000);
    send(8'hA4);
    check("R2 primary write, don't-care bits", 3'b100);
  endtask

  task automatic t_dual();
    sec_cfg_i = {7'h33, 1'b0};
    do_start(); send(8'h67);
    check("R3 dual disabled", 3'b001);
    sec_cfg_i = {7'h33, 1'b1};
    do_start(); send(8'h67);
    check("R4 secondary hit", 3'b111);
    sec_cfg_i = {7'h52, 1'b1};
    do_start(); send(8'hA4);
    check("R4 primary priority", 3'b100);
  endtask

  task automatic t_ten();
    do_start();
    ten_bit_i = 1'b1; prim_addr_i = 10'h2C7; sec_cfg_i = {7'h33, 1'b1};
    do_start(); send(hdr10(prim_addr_i, 1'b0));
    check("R6 header alone", 3'b000);
    send(8'hC7);
    check("R6 ten-bit write", 3'b100);
    do_start(); send(hdr10(prim_addr_i, 1'b1)); send(8'hC7);
    check("R6 R5 ten-bit read", 3'b101);
    do_start(); send(hdr10(10'h1C7, 1'b0)); send(8'hC7);
    check("R7 bad header", 3'b000);
    send(hdr10(prim_addr_i, 1'b0)); send(8'hC7);
    check("R7 stays missed", 3'b000);
    do_start(); send(hdr10(prim_addr_i, 1'b0)); send(8'hC6);
    check("R7 bad low byte", 3'b000);
    do_start(); send(8'h67);
    check("R8 no dual in ten-bit", 3'b001);
  endtask

  task automatic t_collide();
    ten_bit_i = 1'b0; prim_addr_i = 10'h3A5; sec_cfg_i = 8'h00;
    do_start(); send(8'hA4);
    check("R2 setup", 3'b100);
    @(negedge clk); start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hA5;
    @(negedge clk); start_i = 1'b0; byte_vld_i = 1'b0;
    check("R9 start beats byte", 3'b000);
    send(8'hA5);
    check("R9 restart recognises", 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prim7();
    t_dual();
    t_ten();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule